// File: doc/BRIEF.md
# Serial Configuration Bitstream ROM

This block holds a fixed configuration bitstream and sends it out one bit per clock edge on a single data line. The stream is meant to feed a device that loads its configuration serially. A bit-address counter starts at zero and moves forward one step on each rising clock edge while the block is both selected and output-enabled. When the counter reaches the last stored bit, it stays there. The stored bits come from a parameter vector, and bit `i` of that vector sits at address `i`.

Two inputs control the block. The first is a reset/output-enable pin whose active level is chosen by a parameter. While this pin is in its reset state, the counter is forced to zero and the output floats. The second is a deselect pin. While it is high, the counter is likewise cleared and the output floats, and the block also raises a standby flag. The tri-state line is brought out as a data value plus a drive enable, so the pad can be built outside the block.

All outputs are registered. The value presented after a rising edge reflects the input levels sampled at that edge.

Top module: `serial_cfg_rom`

## Requirements
- R1: The parameter `RST_HIGH` sets the reset level of `rst_oe`. With `RST_HIGH`=1, `rst_oe`=1 means reset. With `RST_HIGH`=0, `rst_oe`=0 means reset.
- R2: After an edge at which the reset is in effect, `data_oe` is 0 and the counter is at zero. The next enabled edge therefore presents stored bit 0.
- R3: After an edge at which `sel_n` is 1, `data_oe` is 0, `standby` is 1 and the counter is at zero, whatever level `rst_oe` has.
- R4: After each edge, `standby` equals the `sel_n` level sampled at that edge. It is 0 whenever `sel_n` was 0.
- R5: After an edge at which the reset is not in effect and `sel_n` is 0, `data_oe` is 1. `data_out` then carries the stored bit at the counter's current address, bit `i` of `CONTENT` being address `i`. The counter then advances by one, so the k-th such edge since the last hold presents bit k-1.
- R6: Once the counter holds address `BITS-1`, further enabled edges leave it unchanged, and `data_out` keeps showing bit `BITS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_oe | input | 1 | Reset/output-enable; active level set by `RST_HIGH` |
| sel_n | input | 1 | Deselect; high clears the counter, floats the output and selects standby |
| data_out | output | 1 | Serial bit; meaningful only while `data_oe` is 1 |
| data_oe | output | 1 | Drive enable for the external tri-state data line |
| standby | output | 1 | Standby indication, registered copy of `sel_n` |

## Verification
The bench builds two copies side by side, driven by the same logical stimulus. The first uses `RST_HIGH`=1 with a 64-bit stream. The second uses `RST_HIGH`=0 with an 8-bit stream, and its `rst_oe` pin is driven inverted. The short stream brings the terminal-count freeze into reach within a few edges. A single long enabled run then saturates both copies, one at address 7 and the other at address 63. Holds mid-stream and deselects under both `rst_oe` levels confirm the restart from bit 0 and the standby flag on both polarities.

// File: rtl/cfg_bitrom_pkg.sv
package cfg_bitrom_pkg;

  // Decoded control for one clock edge
  typedef struct packed {
    logic hold;   // counter forced to zero, output floated
    logic desel;  // standby requested
  } bitrom_ctl_t;

endpackage

// File: rtl/bitrom_gate.sv
module bitrom_gate
  import cfg_bitrom_pkg::*;
#(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic        rst_oe,
  input  logic        sel_n,
  output bitrom_ctl_t ctl
);

  logic rst_act;

  generate
    if (RST_HIGH) begin : g_rst_hi
      assign rst_act = rst_oe;
    end else begin : g_rst_lo
      assign rst_act = ~rst_oe;
    end
  endgenerate

  always_comb begin
    ctl.desel = sel_n;
    ctl.hold  = rst_act | sel_n;
  end

endmodule

// File: rtl/bitrom_addr.sv
module bitrom_addr #(
  parameter int BITS = 64,
  localparam int AW  = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic          clk,
  input  logic          hold,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] TC = AW'(BITS - 1);

  always_ff @(posedge clk) begin
    if (hold) begin
      addr <= '0;
    end else if (addr != TC) begin
      addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/bitrom_store.sv
module bitrom_store #(
  parameter int             BITS    = 64,
  parameter logic [BITS-1:0] CONTENT = '0,
  localparam int            AW      = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          bit_q
);

  logic rom [0:BITS-1];

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_cell
      assign rom[i] = CONTENT[i];
    end
  endgenerate

  // registered read port
  always_ff @(posedge clk) begin
    bit_q <= rom[rd_addr];
  end

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
  import cfg_bitrom_pkg::*;
#(
  parameter int             BITS     = 64,
  parameter logic [BITS-1:0] CONTENT  = 64'hC3A5_0F96_7E18_D24B,
  parameter bit             RST_HIGH = 1'b1,
  localparam int            AW       = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic sel_n,
  output logic data_out,
  output logic data_oe,
  output logic standby
);

  bitrom_ctl_t   ctl;
  logic [AW-1:0] addr_q;
  logic          oe_q;
  logic          sb_q;

  bitrom_gate #(.RST_HIGH(RST_HIGH)) u_gate (
    .rst_oe (rst_oe),
    .sel_n  (sel_n),
    .ctl    (ctl)
  );

  bitrom_addr #(.BITS(BITS)) u_addr (
    .clk  (clk),
    .hold (ctl.hold),
    .addr (addr_q)
  );

  bitrom_store #(.BITS(BITS), .CONTENT(CONTENT)) u_store (
    .clk     (clk),
    .rd_addr (addr_q),
    .bit_q   (data_out)
  );

  always_ff @(posedge clk) begin
    oe_q <= ~ctl.hold;
    sb_q <= ctl.desel;
  end

  assign data_oe = oe_q;
  assign standby = sb_q;

endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
  parameter int BITS     = 64,
  parameter bit RST_HIGH = 1'b1,
  localparam int AW      = (BITS > 1) ? $clog2(BITS) : 1
) (
  input logic          clk,
  input logic          rst_oe,
  input logic          sel_n,
  input logic          data_oe,
  input logic          standby,
  input logic [AW-1:0] addr
);

  localparam logic [AW-1:0] TC = AW'(BITS - 1);

  logic primed = 1'b0;
  logic hold_w;

  always_ff @(posedge clk) primed <= 1'b1;

  assign hold_w = (RST_HIGH ? rst_oe : ~rst_oe) | sel_n;

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (!primed)
    hold_w |=> (addr == '0) && !data_oe);

  // R3
  desel_float_chk: assert property (@(posedge clk) disable iff (!primed)
    sel_n |=> standby && !data_oe);

  // R4
  standby_off_chk: assert property (@(posedge clk) disable iff (!primed)
    !sel_n |=> !standby);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!primed)
    (!hold_w && addr != TC) |=> data_oe && (addr == AW'($past(addr) + 1'b1)));

  // R6
  tc_freeze_chk: assert property (@(posedge clk) disable iff (!primed)
    (!hold_w && addr == TC) |=> data_oe && (addr == TC));

endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.BITS(BITS), .RST_HIGH(RST_HIGH)) u_chk (
  .clk     (clk),
  .rst_oe  (rst_oe),
  .sel_n   (sel_n),
  .data_oe (data_oe),
  .standby (standby),
  .addr    (addr_q)
);

// File: tb/tb_serial_cfg_rom.sv
module tb_serial_cfg_rom;

  localparam int CLK_P  = 10;
  localparam int BITS_A = 64;
  localparam logic [BITS_A-1:0] CONT_A = 64'hC3A5_0F96_7E18_D24B;
  localparam int BITS_B = 8;
  localparam logic [BITS_B-1:0] CONT_B = 8'b1011_0010;

  typedef struct {
    logic  oe;
    logic  bit_a;
    logic  bit_b;
    logic  sb;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_drv = 1'b1;
  logic sel_drv = 1'b0;
  logic rst_lo_pin;
  logic dout_a, oe_a, sb_a;
  logic dout_b, oe_b, sb_b;

  int checks = 0;
  int errors = 0;
  int m_a = 0;
  int m_b = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  assign rst_lo_pin = ~rst_drv;

  serial_cfg_rom #(.BITS(BITS_A), .CONTENT(CONT_A), .RST_HIGH(1'b1)) dut (
    .clk(clk), .rst_oe(rst_drv), .sel_n(sel_drv),
    .data_out(dout_a), .data_oe(oe_a), .standby(sb_a)
  );

  serial_cfg_rom #(.BITS(BITS_B), .CONTENT(CONT_B), .RST_HIGH(1'b0)) dut_lo (
    .clk(clk), .rst_oe(rst_lo_pin), .sel_n(sel_drv),
    .data_out(dout_b), .data_oe(oe_b), .standby(sb_b)
  );

  task automatic cmp(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  // driver: r = logical reset, s = deselect
  task automatic step(input logic r, input logic s, input string tag);
    exp_t e;
    logic hold;
    @(negedge clk);
    rst_drv = r;
    sel_drv = s;
    hold    = r | s;
    e.oe    = ~hold;
    e.bit_a = CONT_A[m_a];
    e.bit_b = CONT_B[m_b];
    e.sb    = s;
    e.tag   = tag;
    sb_q.push_back(e);
    if (hold) begin
      m_a = 0;
      m_b = 0;
    end else begin
      if (m_a < BITS_A - 1) m_a++;
      if (m_b < BITS_B - 1) m_b++;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (!finished && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      cmp(e.tag, "oe_hi_pol",  oe_a, e.oe);
      cmp(e.tag, "oe_lo_pol",  oe_b, e.oe);
      cmp(e.tag, "sb_hi_pol",  sb_a, e.sb);
      cmp(e.tag, "sb_lo_pol",  sb_b, e.sb);
      if (e.oe) begin
        cmp(e.tag, "bit_hi_pol", dout_a, e.bit_a);
        cmp(e.tag, "bit_lo_pol", dout_b, e.bit_b);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 R2: reset state on both polarities
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R1");
    // R5: stream from bit 0
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R5");
    // R2: reset mid-stream restarts at bit 0
    step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R2");
    // R3 R4: deselect with reset inactive and active
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R4");
    // R6: long run reaches terminal count on both copies
    step(1'b0, 1'b1, "R3");
    for (int i = 0; i < 72; i++) step(1'b0, 1'b0, "R6");
    // R1: polarity after saturation
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items exp 0", sb_q.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule